// File: doc/BRIEF.md
# Multi-mode 4:2:2 video input capture

This block takes interleaved 8-bit YCbCr 4:2:2 video from a parallel pixel bus and turns it into a stream of luma samples. Each luma sample comes with the chroma byte it shares and a strobe. The bus is presented as two byte lanes, each captured by the chip's I/O ring: `bus_rise` holds the byte sampled on the rising edge of the pixel clock and `bus_fall` holds the byte sampled on the falling edge. A small configuration register selects the capture mode. It can take one byte per cycle on the rising lane for standard or double-rate definition, or one luma and one chroma byte per cycle for double-data-rate capture. In the double-data-rate mode, a two-bit field decides which lane carries luma.

Embedded timing codes are found in every mode. A code is the byte sequence all-ones, zero, zero, then a flag byte. The block decodes the field, vertical-blanking and horizontal-blanking flags from the flag byte, strips the code bytes from the pixel stream and realigns the chroma phase at each start of active video. Optional external horizontal and vertical sync inputs can also realign the phase. They are ignored in the double-rate single-edge mode.

Top module: `vid422_capture`

## Requirements
- R1: After reset, `mode_out` is 000, and `pix_valid`, `fld_f`, `blank_v`, `blank_h`, `sav_seen`, `eav_seen`, `ext_hs` and `ext_vs` are all 0.
- R2: A cycle with `cfg_we`=1 loads `cfg_mode` into the mode register only if it is 000 (standard, single edge), 010 (double data rate) or 111 (double rate, single edge). Any other value leaves `mode_out` unchanged.
- R3: In modes 000 and 111, one byte per cycle is taken from `bus_rise`, with bit 0 as LSB. After a start code the byte order is Cb, Y, Cr, Y. Each Y byte leaves on `pix_y` with `pix_valid`=1 three cycles after the edge that sampled it. It carries the chroma byte taken just before it on `pix_c`, with `pix_c_is_cr`=0 for Cb and 1 for Cr.
- R4: A timing code is all-ones, 0x00, 0x00, then a flag byte. Flag bit 6 is the field flag, bit 5 vertical blanking and bit 4 horizontal blanking (1 = end code, 0 = start code). `fld_f`, `blank_v` and `blank_h` take these bits on the edge that samples the flag byte. On that same edge, `sav_seen` or `eav_seen` pulses for one cycle.
- R5: `pix_valid` is raised only between a start code with bit 5 = 0 and the next end code. The four bytes of a code are never emitted as samples.
- R6: The chroma phase restarts at Cb with the first byte after every start code.
- R7: In mode 010, every cycle carries one luma and one chroma byte. If `cfg_luma_edge` is 11, luma is on `bus_fall` and chroma on `bus_rise`; for any other value it is the reverse. Chroma alternates Cb, Cr from each start code, and the outputs follow one cycle after the edge that sampled the pair. A code takes two cycles: chroma lane all-ones with luma lane 0x00, then chroma lane 0x00 with the flag byte on the luma lane.
- R8: With `cfg_ext_sync`=1 in modes 000 or 010, the byte sampled on the first edge that sees `hsync_n` low after it was high is treated as Cb. `ext_hs` and `ext_vs` show the inverted `hsync_n` and `vsync_n` one cycle later.
- R9: In mode 111, `hsync_n` and `vsync_n` have no effect. `ext_hs` and `ext_vs` stay 0 and the chroma phase is not changed by them.
- R10: Any accepted configuration write clears the code history and the active state, so no sample is flagged valid until the next start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Requested capture mode |
| cfg_luma_edge | input | 2 | Luma lane select for double-data-rate mode |
| cfg_ext_sync | input | 1 | Enable external sync phase alignment |
| bus_rise | input | 8 | Byte sampled on the rising clock edge |
| bus_fall | input | 8 | Byte sampled on the falling clock edge |
| hsync_n | input | 1 | External horizontal sync, active low |
| vsync_n | input | 1 | External vertical sync, active low |
| pix_y | output | 8 | Luma sample |
| pix_c | output | 8 | Chroma sample paired with the luma |
| pix_c_is_cr | output | 1 | 1 when `pix_c` is Cr, 0 when Cb |
| pix_valid | output | 1 | Sample strobe |
| fld_f | output | 1 | Field flag from the last code |
| blank_v | output | 1 | Vertical blanking flag from the last code |
| blank_h | output | 1 | Horizontal blanking flag from the last code |
| sav_seen | output | 1 | One-cycle pulse on a start code |
| eav_seen | output | 1 | One-cycle pulse on an end code |
| ext_hs | output | 1 | Registered external horizontal sync, active high |
| ext_vs | output | 1 | Registered external vertical sync, active high |
| mode_out | output | 3 | Current capture mode |

## Verification
Some properties are checked by the assertions on every cycle. Illegal mode writes must leave the mode stable. Start and end pulses must never coincide, and the code cycle and the cycle after it must carry no sample. A sample must never appear unless the flags showed active, unblanked video. In the double-rate mode, the external sync flags must stay low. Other behaviour can only be shown by the bench's scenarios: the byte ordering, the latency, the Cb/Cr pairing, the choice of luma lane, the phase realignment by a falling horizontal sync, and the flush on a configuration write. Each is checked against an expected stream.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
// Shared types for the 4:2:2 capture block: mode encodings and legality test.
package vc_pkg;
    typedef enum logic [2:0] {
        MODE_SD   = 3'b000,
        MODE_DDR  = 3'b010,
        MODE_ED2X = 3'b111
    } vc_mode_e;

    // Returns 1 when a raw 3-bit value is one of the three supported modes.
    function automatic logic mode_legal(input logic [2:0] m);
        return (m == MODE_SD) || (m == MODE_DDR) || (m == MODE_ED2X);
    endfunction
endpackage

// File: rtl/vc_mode_reg.sv
`timescale 1ns/1ps
// Configuration register. Holds the capture mode, the luma lane choice and the
// external sync enable. Assumes writes arrive as single-cycle strobes; an
// unsupported mode value leaves the previous mode in place.
module vc_mode_reg
    import vc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic [1:0] cfg_luma_edge,
    input  logic       cfg_ext_sync,
    output logic [2:0] mode,
    output logic       is_ddr,
    output logic       luma_on_fall,
    output logic       ext_on
);
    vc_mode_e   mode_q;
    logic [1:0] edge_q;
    logic       ext_q;

    // Register update: load edge and sync fields, load mode only when legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SD;
            edge_q <= 2'b00;
            ext_q  <= 1'b0;
        end else if (cfg_we) begin
            if (mode_legal(cfg_mode)) mode_q <= vc_mode_e'(cfg_mode);
            edge_q <= cfg_luma_edge;
            ext_q  <= cfg_ext_sync;
        end
    end

    // Decoded controls for the datapath.
    always_comb begin
        mode         = mode_q;
        is_ddr       = (mode_q == MODE_DDR);
        luma_on_fall = &edge_q;
        ext_on       = ext_q && (mode_q != MODE_ED2X);
    end
endmodule

// File: rtl/vc_code_track.sv
`timescale 1ns/1ps
// Timing-code tracker. Keeps a short history of incoming bytes (or byte pairs
// in double-data-rate mode) so that a code can be recognised before any of its
// bytes is handed on. Presents the oldest history unit for unpacking, with a
// flag saying whether it may be used. Assumes an 8-bit-style code: all-ones,
// zero run, then a flag byte whose bits DW-2..DW-4 are F, V, H.
module vc_code_track #(
    parameter int DW       = 8,
    parameter int CODE_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          is_ddr,
    input  logic          luma_on_fall,
    input  logic          sol_in,
    input  logic [DW-1:0] din_r,
    input  logic [DW-1:0] din_f,
    output logic [DW-1:0] unit_a,
    output logic [DW-1:0] unit_b,
    output logic          unit_sol,
    output logic          unit_ok,
    output logic          restart,
    output logic          fld_f,
    output logic          blank_v,
    output logic          blank_h,
    output logic          active,
    output logic          sav_seen,
    output logic          eav_seen
);
    localparam int HIST = CODE_LEN - 1;
    localparam int SKW  = $clog2(HIST + 1);
    localparam int FB   = DW - 2;
    localparam int VB   = DW - 3;
    localparam int HB   = DW - 4;

    logic [DW-1:0] a_in, b_in;
    logic [DW-1:0] hist_a [HIST];
    logic [DW-1:0] hist_b [HIST];
    logic [HIST-1:0] hist_s;
    logic [SKW-1:0]  skip;
    logic code_hit, tail_zero, xy_f, xy_v, xy_h;

    // Lane steering: a is chroma (or the single byte), b is luma in DDR.
    always_comb begin
        if (is_ddr && !luma_on_fall) begin
            a_in = din_f;
            b_in = din_r;
        end else begin
            a_in = din_r;
            b_in = din_f;
        end
    end

    // Code recognition on the history plus the newest unit.
    always_comb begin
        tail_zero = 1'b1;
        for (int i = 1; i < HIST; i++) begin
            if (hist_a[i] != '0) tail_zero = 1'b0;
        end
        if (is_ddr) begin
            code_hit = (hist_a[HIST-1] == '1) && (hist_b[HIST-1] == '0) && (a_in == '0);
            xy_f     = b_in[FB];
            xy_v     = b_in[VB];
            xy_h     = b_in[HB];
            unit_a   = hist_a[HIST-1];
            unit_sol = hist_s[HIST-1];
        end else begin
            code_hit = (hist_a[0] == '1) && tail_zero;
            xy_f     = a_in[FB];
            xy_v     = a_in[VB];
            xy_h     = a_in[HB];
            unit_a   = hist_a[0];
            unit_sol = hist_s[0];
        end
        unit_b  = hist_b[HIST-1];
        unit_ok = !code_hit && (skip == '0);
        restart = code_hit && !xy_h;
    end

    // History shift: oldest at index 0, newest at HIST-1.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < HIST; i++) begin
                hist_a[i] <= '0;
                hist_b[i] <= '0;
            end
            hist_s <= '0;
        end else begin
            for (int i = 0; i < HIST - 1; i++) begin
                hist_a[i] <= hist_a[i+1];
                hist_b[i] <= hist_b[i+1];
                hist_s[i] <= hist_s[i+1];
            end
            hist_a[HIST-1] <= a_in;
            hist_b[HIST-1] <= b_in;
            hist_s[HIST-1] <= sol_in;
        end
    end

    // Code state: flag latch, active window, pulses and code-byte suppression.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            skip     <= '0;
            fld_f    <= 1'b0;
            blank_v  <= 1'b0;
            blank_h  <= 1'b0;
            active   <= 1'b0;
            sav_seen <= 1'b0;
            eav_seen <= 1'b0;
        end else begin
            sav_seen <= 1'b0;
            eav_seen <= 1'b0;
            if (code_hit) begin
                skip     <= is_ddr ? SKW'(1) : SKW'(HIST);
                fld_f    <= xy_f;
                blank_v  <= xy_v;
                blank_h  <= xy_h;
                active   <= !xy_h && !xy_v;
                sav_seen <= !xy_h;
                eav_seen <= xy_h;
            end else if (skip != '0) begin
                skip <= skip - SKW'(1);
            end
        end
    end
endmodule

// File: rtl/vc_unpack.sv
`timescale 1ns/1ps
// 4:2:2 unpacker. Takes one usable unit per cycle from the code tracker and
// pairs each luma byte with its chroma byte. Assumes the tracker already
// removed code bytes; a start-of-line flag on a unit forces it to be Cb.
module vc_unpack #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          is_ddr,
    input  logic          active,
    input  logic          restart,
    input  logic          unit_ok,
    input  logic          unit_sol,
    input  logic [DW-1:0] unit_a,
    input  logic [DW-1:0] unit_b,
    output logic [DW-1:0] pix_y,
    output logic [DW-1:0] pix_c,
    output logic          pix_c_is_cr,
    output logic          pix_valid
);
    logic [1:0]    phase, eff;
    logic [DW-1:0] chroma_q;

    // Effective phase: external start of line forces Cb.
    always_comb eff = unit_sol ? 2'd0 : phase;

    // Phase advance and sample emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= 2'd0;
            chroma_q    <= '0;
            pix_y       <= '0;
            pix_c       <= '0;
            pix_c_is_cr <= 1'b0;
            pix_valid   <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            if (flush || restart) begin
                phase <= 2'd0;
            end else if (unit_ok) begin
                if (is_ddr) begin
                    pix_y       <= unit_b;
                    pix_c       <= unit_a;
                    pix_c_is_cr <= eff[0];
                    pix_valid   <= active;
                    phase       <= {1'b0, ~eff[0]};
                end else begin
                    case (eff)
                        2'd0, 2'd2: chroma_q <= unit_a;
                        default: begin
                            pix_y       <= unit_a;
                            pix_c       <= chroma_q;
                            pix_c_is_cr <= eff[1];
                            pix_valid   <= active;
                        end
                    endcase
                    phase <= eff + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/vid422_capture.sv
`timescale 1ns/1ps
// Top of the multi-mode 4:2:2 capture block. Assumes the two byte lanes were
// captured on the rising and falling pixel clock edges by the I/O ring and are
// presented together in this clock domain. Wires the configuration register,
// external sync edge logic, code tracker and unpacker.
module vid422_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_mode,
    input  logic [1:0]    cfg_luma_edge,
    input  logic          cfg_ext_sync,
    input  logic [DW-1:0] bus_rise,
    input  logic [DW-1:0] bus_fall,
    input  logic          hsync_n,
    input  logic          vsync_n,
    output logic [DW-1:0] pix_y,
    output logic [DW-1:0] pix_c,
    output logic          pix_c_is_cr,
    output logic          pix_valid,
    output logic          fld_f,
    output logic          blank_v,
    output logic          blank_h,
    output logic          sav_seen,
    output logic          eav_seen,
    output logic          ext_hs,
    output logic          ext_vs,
    output logic [2:0]    mode_out
);
    logic is_ddr, luma_on_fall, ext_on, hs_prev, sol_in;
    logic active, restart, unit_ok, unit_sol;
    logic [DW-1:0] unit_a, unit_b;

    vc_mode_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_luma_edge(cfg_luma_edge), .cfg_ext_sync(cfg_ext_sync),
        .mode(mode_out), .is_ddr(is_ddr), .luma_on_fall(luma_on_fall), .ext_on(ext_on)
    );

    // External sync: falling-edge detect and registered active-high flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_prev <= 1'b1;
            ext_hs  <= 1'b0;
            ext_vs  <= 1'b0;
        end else begin
            hs_prev <= hsync_n;
            ext_hs  <= ext_on && !hsync_n;
            ext_vs  <= ext_on && !vsync_n;
        end
    end

    // Start of line: first low sample of hsync_n while sync is honoured.
    always_comb sol_in = ext_on && hs_prev && !hsync_n;

    vc_code_track #(.DW(DW)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(cfg_we), .is_ddr(is_ddr),
        .luma_on_fall(luma_on_fall), .sol_in(sol_in), .din_r(bus_rise), .din_f(bus_fall),
        .unit_a(unit_a), .unit_b(unit_b), .unit_sol(unit_sol), .unit_ok(unit_ok),
        .restart(restart), .fld_f(fld_f), .blank_v(blank_v), .blank_h(blank_h),
        .active(active), .sav_seen(sav_seen), .eav_seen(eav_seen)
    );

    vc_unpack #(.DW(DW)) u_unpack (
        .clk(clk), .rst_n(rst_n), .flush(cfg_we), .is_ddr(is_ddr), .active(active),
        .restart(restart), .unit_ok(unit_ok), .unit_sol(unit_sol),
        .unit_a(unit_a), .unit_b(unit_b), .pix_y(pix_y), .pix_c(pix_c),
        .pix_c_is_cr(pix_c_is_cr), .pix_valid(pix_valid)
    );
endmodule

// File: rtl/vid422_capture_chk.sv
`timescale 1ns/1ps
// Property checker for vid422_capture, attached by bind. Observes ports only.
module vid422_capture_chk
    import vc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_mode,
    input logic [2:0] mode_out,
    input logic       pix_valid,
    input logic       blank_v,
    input logic       blank_h,
    input logic       sav_seen,
    input logic       eav_seen,
    input logic       ext_hs,
    input logic       ext_vs
);
    // R2: an unsupported mode write leaves the mode unchanged.
    a_r2_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !mode_legal(cfg_mode)) |=> $stable(mode_out));

    // R4: start and end pulses never coincide.
    a_r4_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sav_seen && eav_seen));

    // R5: the cycle that completes a code carries no sample.
    a_r5_code_not_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_seen || eav_seen) |-> !pix_valid);

    // R5: a sample needs unblanked flags in the previous cycle.
    a_r5_valid_unblanked: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(!blank_h && !blank_v));

    // R6: the cycle after a start code is still a code byte, never a sample.
    a_r6_after_sav: assert property (@(posedge clk) disable iff (!rst_n)
        sav_seen |=> !pix_valid);

    // R9: double-rate single-edge mode keeps external sync flags low.
    a_r9_ed2x_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 3'b111) |=> (!ext_hs && !ext_vs));
endmodule

bind vid422_capture vid422_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .mode_out(mode_out), .pix_valid(pix_valid), .blank_v(blank_v),
    .blank_h(blank_h), .sav_seen(sav_seen), .eav_seen(eav_seen),
    .ext_hs(ext_hs), .ext_vs(ext_vs)
);

// File: tb/vid422_capture_test.sv
`timescale 1ns/1ps
// Self-checking bench for vid422_capture: table-driven SD stream, then
// directed tests for reset, mode writes, DDR lanes, sync and flush.
module vid422_capture_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic [1:0] cfg_luma_edge = 2'b00;
    logic       cfg_ext_sync = 1'b0;
    logic [7:0] bus_rise = 8'h00;
    logic [7:0] bus_fall = 8'h00;
    logic       hsync_n = 1'b1;
    logic       vsync_n = 1'b1;
    logic [7:0] pix_y, pix_c;
    logic       pix_c_is_cr, pix_valid, fld_f, blank_v, blank_h;
    logic       sav_seen, eav_seen, ext_hs, ext_vs;
    logic [2:0] mode_out;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    vid422_capture uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_luma_edge(cfg_luma_edge), .cfg_ext_sync(cfg_ext_sync),
        .bus_rise(bus_rise), .bus_fall(bus_fall), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .pix_y(pix_y), .pix_c(pix_c), .pix_c_is_cr(pix_c_is_cr), .pix_valid(pix_valid),
        .fld_f(fld_f), .blank_v(blank_v), .blank_h(blank_h), .sav_seen(sav_seen),
        .eav_seen(eav_seen), .ext_hs(ext_hs), .ext_vs(ext_vs), .mode_out(mode_out)
    );

    typedef struct packed {
        logic [7:0] b;
        logic       v;
        logic [7:0] y;
        logic [7:0] c;
        logic       cr;
    } vec_t;

    // SD stream: start code, two pixel pairs, end code; expected outputs after
    // each edge (outputs lag the sampled byte by three cycles).
    localparam vec_t TBL [16] = '{
        '{8'hFF, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h80, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h10, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h20, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h30, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h40, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h11, 1'b1, 8'h20, 8'h10, 1'b0},
        '{8'h21, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h31, 1'b1, 8'h40, 8'h30, 1'b1},
        '{8'h41, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'hFF, 1'b1, 8'h21, 8'h11, 1'b0},
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0},
        '{8'h00, 1'b1, 8'h41, 8'h31, 1'b1},
        '{8'h90, 1'b0, 8'h00, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of single-edge data; returns just after the sampling edge.
    task automatic send(input logic [7:0] b, input logic hs);
        @(negedge clk);
        cfg_we = 1'b0;
        bus_rise = b;
        bus_fall = 8'h00;
        hsync_n = hs;
        @(posedge clk);
        #1;
    endtask

    // One cycle of DDR data, steering luma per the selected lane.
    task automatic send_pair(input logic [7:0] y, input logic [7:0] c);
        @(negedge clk);
        cfg_we = 1'b0;
        if (cfg_luma_edge == 2'b11) begin
            bus_fall = y;
            bus_rise = c;
        end else begin
            bus_rise = y;
            bus_fall = c;
        end
        hsync_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [2:0] m, input logic [1:0] e, input logic x);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_mode = m;
        cfg_luma_edge = e;
        cfg_ext_sync = x;
        bus_rise = 8'h00;
        bus_fall = 8'h00;
        @(posedge clk);
        #1;
    endtask

    task automatic sav_code();
        send(8'hFF, 1'b1);
        send(8'h00, 1'b1);
        send(8'h00, 1'b1);
        send(8'h80, 1'b1);
    endtask

    initial begin
        #600000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 mode_out", 32'(mode_out), 32'h0);
        chk("R1 pix_valid", 32'(pix_valid), 32'h0);
        chk("R1 flags", 32'({fld_f, blank_v, blank_h, sav_seen, eav_seen, ext_hs, ext_vs}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R5 R6: table-driven SD stream
        cfg(3'b000, 2'b00, 1'b0);
        for (int i = 0; i < 16; i++) begin
            send(TBL[i].b, 1'b1);
            chk($sformatf("R3 R5 valid step %0d", i), 32'(pix_valid), 32'(TBL[i].v));
            if (TBL[i].v) begin
                chk($sformatf("R3 y step %0d", i), 32'(pix_y), 32'(TBL[i].y));
                chk($sformatf("R3 R6 c step %0d", i), 32'(pix_c), 32'(TBL[i].c));
                chk($sformatf("R3 cr step %0d", i), 32'(pix_c_is_cr), 32'(TBL[i].cr));
            end
            if (i == 3) chk("R4 sav pulse/flags", 32'({sav_seen, eav_seen, fld_f, blank_v, blank_h}), 32'b10000);
            if (i == 15) chk("R4 eav pulse/flags", 32'({sav_seen, eav_seen, fld_f, blank_v, blank_h}), 32'b01001);
        end

        // R2: illegal mode writes are ignored, legal ones taken
        cfg(3'b011, 2'b00, 1'b0);
        chk("R2 illegal 011 kept", 32'(mode_out), 32'h0);
        cfg(3'b010, 2'b00, 1'b0);
        chk("R2 legal 010", 32'(mode_out), 32'h2);
        cfg(3'b101, 2'b00, 1'b0);
        chk("R2 illegal 101 kept", 32'(mode_out), 32'h2);

        // R7: DDR, luma on rising lane (edge select 00)
        send_pair(8'h00, 8'hFF);
        send_pair(8'h80, 8'h00);
        chk("R7 ddr sav", 32'(sav_seen), 32'h1);
        send_pair(8'h50, 8'h60);
        chk("R7 ddr code skipped", 32'(pix_valid), 32'h0);
        send_pair(8'h51, 8'h61);
        chk("R7 ddr first valid", 32'({pix_valid, pix_y, pix_c, pix_c_is_cr}), 32'({1'b1, 8'h50, 8'h60, 1'b0}));
        send_pair(8'h01, 8'h02);
        chk("R7 ddr second Cr", 32'({pix_valid, pix_y, pix_c, pix_c_is_cr}), 32'({1'b1, 8'h51, 8'h61, 1'b1}));

        // R7: DDR, luma on falling lane (edge select 11)
        cfg(3'b010, 2'b11, 1'b0);
        send_pair(8'h00, 8'hFF);
        send_pair(8'h80, 8'h00);
        send_pair(8'h70, 8'h72);
        send_pair(8'h71, 8'h73);
        chk("R7 ddr fall-lane luma", 32'({pix_valid, pix_y, pix_c, pix_c_is_cr}), 32'({1'b1, 8'h70, 8'h72, 1'b0}));

        // R5 R4: start code with vertical blanking gives no samples
        cfg(3'b000, 2'b00, 1'b0);
        send(8'hFF, 1'b1);
        send(8'h00, 1'b1);
        send(8'h00, 1'b1);
        send(8'hA0, 1'b1);
        chk("R4 v flag", 32'({sav_seen, blank_v, blank_h}), 32'b110);
        begin
            int seen = 0;
            send(8'h10, 1'b1);
            if (pix_valid) seen++;
            send(8'h20, 1'b1);
            if (pix_valid) seen++;
            for (int k = 0; k < 5; k++) begin
                send(8'h05, 1'b1);
                if (pix_valid) seen++;
            end
            chk("R5 no valid in vblank", 32'(seen), 32'h0);
        end
        send(8'hFF, 1'b1);
        send(8'h00, 1'b1);
        send(8'h00, 1'b1);
        send(8'hF0, 1'b1);
        chk("R4 field flag", 32'({eav_seen, fld_f, blank_v, blank_h}), 32'b1111);

        // R8: external sync in SD realigns phase to Cb
        cfg(3'b000, 2'b00, 1'b1);
        sav_code();
        send(8'h10, 1'b1);
        send(8'h20, 1'b1);
        send(8'h30, 1'b1);
        send(8'h15, 1'b0);
        chk("R8 ext_hs", 32'(ext_hs), 32'h1);
        send(8'h25, 1'b1);
        send(8'h03, 1'b1);
        send(8'h03, 1'b1);
        send(8'h03, 1'b1);
        chk("R8 hsync forces Cb", 32'({pix_valid, pix_y, pix_c, pix_c_is_cr}), 32'({1'b1, 8'h25, 8'h15, 1'b0}));

        // R9: double-rate mode ignores external sync
        cfg(3'b111, 2'b00, 1'b1);
        chk("R9 mode 111", 32'(mode_out), 32'h7);
        sav_code();
        send(8'h10, 1'b1);
        send(8'h20, 1'b1);
        send(8'h30, 1'b1);
        send(8'h15, 1'b0);
        chk("R9 ext_hs low", 32'(ext_hs), 32'h0);
        send(8'h25, 1'b1);
        send(8'h03, 1'b1);
        send(8'h03, 1'b1);
        chk("R9 phase unchanged", 32'({pix_valid, pix_y, pix_c, pix_c_is_cr}), 32'({1'b1, 8'h15, 8'h30, 1'b1}));

        // R10: a configuration write flushes the active state
        cfg(3'b000, 2'b00, 1'b0);
        sav_code();
        send(8'h10, 1'b1);
        send(8'h20, 1'b1);
        cfg(3'b000, 2'b00, 1'b0);
        begin
            int seen = 0;
            send(8'h30, 1'b1);
            if (pix_valid) seen++;
            send(8'h40, 1'b1);
            if (pix_valid) seen++;
            for (int k = 0; k < 6; k++) begin
                send(8'h06, 1'b1);
                if (pix_valid) seen++;
            end
            chk("R10 no valid after flush", 32'(seen), 32'h0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule